// File: doc/BRIEF.md
# Reset and Low-Power Mode Controller

This block sits beside the CPU of a small 8-bit microcontroller and owns two jobs: deciding when the chip is in reset, and running the chip's sleep states. A raw, asynchronous reset pin is synchronised and must stay high for two machine cycles (24 oscillator clocks) before the internal reset is raised. A supply brown-out flag forces weak pull-ups on the port pins while it is active, and once it clears, a recovery delay runs and then an internal reset pulse is issued.

Software asks for a sleep state by pulsing one of two request strobes from the power-control register. Idle stops only the CPU clock. The peripherals, interrupt logic and RAM keep running, and any enabled interrupt or a reset pin assertion wakes the CPU. Power-down also stops the peripherals and the oscillator, and only a reset leaves it. When the reset pin ends idle, the CPU runs again for a short time before the internal reset takes over. During that window, RAM writes are inhibited. Port writes are not.

Top module: `rstpwr_ctrl`

## Requirements
- R1: `port_ones` goes high at the same moment as `rst_pin_a` rises, with no clock edge needed, and stays high while `rst_int` is high.
- R2: If `rst_pin_a` is held high across 24 consecutive rising edges and beyond, `rst_int` rises on the 26th rising edge after the pin rose (two synchroniser stages plus 24 qualification clocks). A pin pulse that spans only 23 rising edges causes no internal reset.
- R3: A pin-driven `rst_int` falls on the 3rd rising edge after `rst_pin_a` falls.
- R4: One cycle of `idle_set` in run mode clears `cpu_clk_en` after the next edge. `per_clk_en` and `osc_en` stay at 1.
- R5: In idle, `irq_pend` sets `cpu_clk_en` back to 1 after the next edge. The idle request is then cleared, so the CPU stays awake without a new request.
- R6: One cycle of `pdown_set` clears `cpu_clk_en`, `per_clk_en` and `osc_en` after the next edge. `irq_pend` has no effect while powered down.
- R7: If `idle_set` and `pdown_set` arrive in the same cycle, power-down is entered.
- R8: In power-down, `osc_en` returns to 1 as soon as `rst_pin_a` is high. The mode ends only through the internal reset. `cpu_clk_en` and `per_clk_en` return to 1 one edge after `rst_int` rises.
- R9: When the reset pin ends idle, `cpu_clk_en` and `ram_wr_blk` rise on the 3rd edge after the pin rises. `ram_wr_blk` falls on the same edge at which `rst_int` rises.
- R10: `port_weak_pu` follows `bod_flag` with a delay of two rising edges, for both its rise and its fall.
- R11: After the synchronised `bod_flag` clears, `rst_int` rises `BOD_DLY` edges later, which is `BOD_DLY`+2 edges after the flag falls. It then stays high for exactly 24 cycles. A new assertion of the flag during the delay restarts the delay.
- R12: Sleep requests that arrive while `rst_int` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_pin_a | input | 1 | Raw reset pin, active high, asynchronous |
| idle_set | input | 1 | One-cycle software request for idle |
| pdown_set | input | 1 | One-cycle software request for power-down |
| irq_pend | input | 1 | OR of enabled pending interrupt requests |
| bod_flag | input | 1 | Brown-out comparator flag, high while supply is low |
| rst_int | output | 1 | Internal reset to the core |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| ram_wr_blk | output | 1 | Internal RAM write inhibit |
| port_ones | output | 1 | Forces port output latches to 1 |
| port_weak_pu | output | 1 | Forces weak pull-high on port pins |

## Verification
Every result has a fixed latency, counted in rising edges from the moment the bench drives a stimulus:
- `port_ones` and the wake of `osc_en` respond with no edge at all.
- Sleep entry and interrupt wake take one edge.
- The weak pull-up takes two edges.
- A reset release takes three edges, and the opening of the idle-exit window also takes three.
- A reset raise takes 26 edges.
- A brown-out reset takes `BOD_DLY`+2 edges, and its pulse lasts 24.

The bench drives inputs at the falling edge and counts whole falling edges before each sample. It checks the cycle just before each due edge as well as the cycle of the edge itself, so that an early or late transition by one cycle is caught.

// File: rtl/rstpwr_pkg.sv
package rstpwr_pkg;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_PDOWN = 2'd2
  } mode_t;

  // oscillator clocks the pin must be seen high before reset is accepted
  function automatic int qual_clks(input int clks_per_mc, input int mcs);
    return clks_per_mc * mcs;
  endfunction

  // counter width able to hold values 0..limit
  function automatic int cnt_width(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

  // next sleep state; a reset or power-down request takes priority
  function automatic mode_t mode_next(input mode_t cur, input logic rst,
                                      input logic want_idle, input logic want_pd,
                                      input logic irq, input logic pin);
    mode_t nxt;
    nxt = cur;
    if (rst) nxt = MODE_RUN;
    else begin
      case (cur)
        MODE_RUN:  if (want_pd) nxt = MODE_PDOWN;
                   else if (want_idle) nxt = MODE_IDLE;
        MODE_IDLE: if (irq || pin) nxt = MODE_RUN;
        default:   nxt = MODE_PDOWN;
      endcase
    end
    return nxt;
  endfunction

endpackage

// File: rtl/rstpwr_sync.sv
module rstpwr_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] d_a,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d_a;
      q    <= meta;
    end
  end
endmodule

// File: rtl/rstpwr_qual.sv
module rstpwr_qual #(
  parameter int QUAL = 24
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_sync,
  output logic pin_rst
);
  localparam int CW = rstpwr_pkg::cnt_width(QUAL);

  logic [CW-1:0] cnt;
  logic          hit_last;

  assign hit_last = (cnt == CW'(QUAL - 1));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt     <= '0;
      pin_rst <= 1'b0;
    end else if (!pin_sync) begin
      cnt     <= '0;
      pin_rst <= 1'b0;
    end else begin
      if (cnt != CW'(QUAL)) cnt <= cnt + 1'b1;
      if (hit_last) pin_rst <= 1'b1;
    end
  end

  assert_rise_needs_pin_R2: assert property (@(posedge clk) disable iff (!por_n)
    $rose(pin_rst) |-> $past(pin_sync));
  assert_release_on_low_R3: assert property (@(posedge clk) disable iff (!por_n)
    !pin_sync |=> !pin_rst);
endmodule

// File: rtl/rstpwr_bod.sv
module rstpwr_bod #(
  parameter int DLY = 180000,
  parameter int LEN = 24
) (
  input  logic clk,
  input  logic por_n,
  input  logic bod_sync,
  output logic bod_rst
);
  localparam int DW = rstpwr_pkg::cnt_width(DLY);
  localparam int PW = rstpwr_pkg::cnt_width(LEN);

  logic          armed;
  logic [DW-1:0] dly;
  logic [PW-1:0] pcnt;
  logic          fire;

  assign fire = armed && !bod_sync && (dly == DW'(DLY - 1));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      armed   <= 1'b0;
      dly     <= '0;
      pcnt    <= '0;
      bod_rst <= 1'b0;
    end else begin
      if (bod_rst) begin
        if (pcnt == '0) bod_rst <= 1'b0;
        else            pcnt <= pcnt - 1'b1;
      end
      if (bod_sync) begin
        armed <= 1'b1;
        dly   <= '0;
      end else if (fire) begin
        armed   <= 1'b0;
        dly     <= '0;
        bod_rst <= 1'b1;
        pcnt    <= PW'(LEN - 1);
      end else if (armed) begin
        dly <= dly + 1'b1;
      end
    end
  end

  assert_bod_rst_after_clear_R11: assert property (@(posedge clk) disable iff (!por_n)
    $rose(bod_rst) |-> !$past(bod_sync));
endmodule

// File: rtl/rstpwr_mode.sv
module rstpwr_mode
  import rstpwr_pkg::*;
(
  input  logic  clk,
  input  logic  por_n,
  input  logic  rst_i,
  input  logic  pin_sync,
  input  logic  idle_set,
  input  logic  pdown_set,
  input  logic  irq_pend,
  output mode_t mode,
  output logic  idle_win
);
  mode_t mode_d;
  logic  pin_wake;

  assign mode_d   = mode_next(mode, rst_i, idle_set, pdown_set, irq_pend, pin_sync);
  assign pin_wake = (mode == MODE_IDLE) && pin_sync && !rst_i;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mode     <= MODE_RUN;
      idle_win <= 1'b0;
    end else begin
      mode <= mode_d;
      if (rst_i || !pin_sync) idle_win <= 1'b0;
      else if (pin_wake)      idle_win <= 1'b1;
    end
  end

  assert_pd_wins_R7: assert property (@(posedge clk) disable iff (!por_n)
    (mode == MODE_RUN && !rst_i && pdown_set) |=> (mode == MODE_PDOWN));
  assert_pd_only_reset_exit_R8: assert property (@(posedge clk) disable iff (!por_n)
    (mode == MODE_PDOWN && !rst_i) |=> (mode == MODE_PDOWN));
  assert_irq_wakes_idle_R5: assert property (@(posedge clk) disable iff (!por_n)
    (mode == MODE_IDLE && irq_pend && !rst_i) |=> (mode == MODE_RUN));
  assert_window_from_idle_R9: assert property (@(posedge clk) disable iff (!por_n)
    $rose(idle_win) |-> $past(mode == MODE_IDLE));
  assert_reset_blocks_sleep_R12: assert property (@(posedge clk) disable iff (!por_n)
    rst_i |=> (mode == MODE_RUN));
endmodule

// File: rtl/rstpwr_ctrl.sv
module rstpwr_ctrl
  import rstpwr_pkg::*;
#(
  parameter int MC_CLKS = 12,
  parameter int QUAL_MC = 2,
  parameter int BOD_DLY = 180000
) (
  input  logic clk_osc,
  input  logic por_n,
  input  logic rst_pin_a,
  input  logic idle_set,
  input  logic pdown_set,
  input  logic irq_pend,
  input  logic bod_flag,
  output logic rst_int,
  output logic cpu_clk_en,
  output logic per_clk_en,
  output logic osc_en,
  output logic ram_wr_blk,
  output logic port_ones,
  output logic port_weak_pu
);
  localparam int QUAL = qual_clks(MC_CLKS, QUAL_MC);

  logic [1:0] sync_q;
  logic       pin_sync;
  logic       bod_sync;
  logic       pin_rst;
  logic       bod_rst;
  logic       idle_win;
  mode_t      mode;

  rstpwr_sync #(.W(2)) u_sync (
    .clk(clk_osc), .por_n(por_n), .d_a({bod_flag, rst_pin_a}), .q(sync_q)
  );
  assign pin_sync = sync_q[0];
  assign bod_sync = sync_q[1];

  rstpwr_qual #(.QUAL(QUAL)) u_qual (
    .clk(clk_osc), .por_n(por_n), .pin_sync(pin_sync), .pin_rst(pin_rst)
  );

  rstpwr_bod #(.DLY(BOD_DLY), .LEN(QUAL)) u_bod (
    .clk(clk_osc), .por_n(por_n), .bod_sync(bod_sync), .bod_rst(bod_rst)
  );

  rstpwr_mode u_mode (
    .clk(clk_osc), .por_n(por_n), .rst_i(rst_int), .pin_sync(pin_sync),
    .idle_set(idle_set), .pdown_set(pdown_set), .irq_pend(irq_pend),
    .mode(mode), .idle_win(idle_win)
  );

  assign rst_int      = pin_rst | bod_rst;
  assign cpu_clk_en   = (mode == MODE_RUN);
  assign per_clk_en   = (mode != MODE_PDOWN);
  assign osc_en       = (mode != MODE_PDOWN) | rst_pin_a;
  assign ram_wr_blk   = idle_win & ~rst_int;
  assign port_ones    = rst_pin_a | rst_int;
  assign port_weak_pu = bod_sync;

  assert_ports_high_in_reset_R1: assert property (@(posedge clk_osc) disable iff (!por_n)
    rst_int |-> port_ones);
  assert_pd_stops_clocks_R6: assert property (@(posedge clk_osc) disable iff (!por_n)
    (mode == MODE_PDOWN && !rst_pin_a) |-> (!osc_en && !per_clk_en && !cpu_clk_en));
  assert_no_block_in_reset_R9: assert property (@(posedge clk_osc) disable iff (!por_n)
    ram_wr_blk |-> !rst_int);
endmodule

// File: tb/rstpwr_ctrl_tb.sv
module rstpwr_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BOD_DLY    = 40;

  logic clk_osc = 1'b0;
  logic por_n = 1'b0, rst_pin_a = 1'b0, idle_set = 1'b0, pdown_set = 1'b0;
  logic irq_pend = 1'b0, bod_flag = 1'b0;
  logic rst_int, cpu_clk_en, per_clk_en, osc_en, ram_wr_blk, port_ones, port_weak_pu;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk_osc = ~clk_osc;

  rstpwr_ctrl #(.BOD_DLY(BOD_DLY)) u_dut (
    .clk_osc(clk_osc), .por_n(por_n), .rst_pin_a(rst_pin_a), .idle_set(idle_set),
    .pdown_set(pdown_set), .irq_pend(irq_pend), .bod_flag(bod_flag),
    .rst_int(rst_int), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .osc_en(osc_en), .ram_wr_blk(ram_wr_blk), .port_ones(port_ones),
    .port_weak_pu(port_weak_pu)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk_osc);
  endtask

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic pulse_req(input logic i, input logic p);
    idle_set = i; pdown_set = p;
    tick(1);
    idle_set = 1'b0; pdown_set = 1'b0;
  endtask

  task automatic t_reset_state;
    chk(rst_int, 1'b0, "R2", "rst_int after power-on");
    chk(cpu_clk_en, 1'b1, "R4", "cpu_clk_en after power-on");
    chk(per_clk_en, 1'b1, "R4", "per_clk_en after power-on");
    chk(osc_en, 1'b1, "R6", "osc_en after power-on");
    chk(ram_wr_blk, 1'b0, "R9", "ram_wr_blk after power-on");
    chk(port_ones, 1'b0, "R1", "port_ones after power-on");
    chk(port_weak_pu, 1'b0, "R10", "port_weak_pu after power-on");
  endtask

  task automatic t_pin_qualify;
    rst_pin_a = 1'b1;
    #1 chk(port_ones, 1'b1, "R1", "port_ones immediate on pin");
    tick(25);
    chk(rst_int, 1'b0, "R2", "rst_int before edge 26");
    tick(1);
    chk(rst_int, 1'b1, "R2", "rst_int at edge 26");
    rst_pin_a = 1'b0;
    tick(2);
    chk(rst_int, 1'b1, "R3", "rst_int held 2 edges after pin low");
    chk(port_ones, 1'b1, "R1", "port_ones held during rst_int");
    tick(1);
    chk(rst_int, 1'b0, "R3", "rst_int released at edge 3");
    chk(port_ones, 1'b0, "R1", "port_ones after release");
  endtask

  task automatic t_short_pulse;
    logic seen;
    seen = 1'b0;
    rst_pin_a = 1'b1;
    for (int i = 0; i < 23; i++) begin tick(1); seen |= rst_int; end
    rst_pin_a = 1'b0;
    for (int i = 0; i < 10; i++) begin tick(1); seen |= rst_int; end
    chk(seen, 1'b0, "R2", "23-edge pin pulse must not reset");
  endtask

  task automatic t_idle_irq;
    pulse_req(1'b1, 1'b0);
    chk(cpu_clk_en, 1'b0, "R4", "cpu_clk_en in idle");
    chk(per_clk_en, 1'b1, "R4", "per_clk_en in idle");
    chk(osc_en, 1'b1, "R4", "osc_en in idle");
    tick(5);
    chk(cpu_clk_en, 1'b0, "R4", "idle persists");
    irq_pend = 1'b1;
    tick(1);
    irq_pend = 1'b0;
    chk(cpu_clk_en, 1'b1, "R5", "interrupt wakes idle");
    tick(5);
    chk(cpu_clk_en, 1'b1, "R5", "idle request cleared after wake");
  endtask

  task automatic t_pdown_wake(input logic both);
    pulse_req(both, 1'b1);
    chk(cpu_clk_en, 1'b0, both ? "R7" : "R6", "cpu_clk_en in power-down");
    chk(per_clk_en, 1'b0, both ? "R7" : "R6", "per_clk_en in power-down");
    chk(osc_en, 1'b0, both ? "R7" : "R6", "osc_en in power-down");
    irq_pend = 1'b1;
    tick(5);
    irq_pend = 1'b0;
    chk(per_clk_en, 1'b0, "R6", "interrupt ignored in power-down");
    rst_pin_a = 1'b1;
    #1 chk(osc_en, 1'b1, "R8", "osc_en wakes with pin");
    tick(26);
    chk(rst_int, 1'b1, "R8", "reset raised in power-down");
    chk(per_clk_en, 1'b0, "R8", "still powered down at reset edge");
    tick(1);
    chk(cpu_clk_en, 1'b1, "R8", "cpu clock back after reset");
    chk(per_clk_en, 1'b1, "R8", "peripheral clock back after reset");
    rst_pin_a = 1'b0;
    tick(4);
    chk(rst_int, 1'b0, "R8", "reset released after wake");
  endtask

  task automatic t_idle_pin_exit;
    pulse_req(1'b1, 1'b0);
    rst_pin_a = 1'b1;
    tick(2);
    chk(cpu_clk_en, 1'b0, "R9", "still idle at edge 2");
    chk(ram_wr_blk, 1'b0, "R9", "no block at edge 2");
    tick(1);
    chk(cpu_clk_en, 1'b1, "R9", "cpu resumes at edge 3");
    chk(ram_wr_blk, 1'b1, "R9", "RAM blocked at edge 3");
    tick(22);
    chk(ram_wr_blk, 1'b1, "R9", "RAM blocked at edge 25");
    tick(1);
    chk(ram_wr_blk, 1'b0, "R9", "block drops when reset rises");
    chk(rst_int, 1'b1, "R9", "reset takes over at edge 26");
    rst_pin_a = 1'b0;
    tick(4);
  endtask

  task automatic t_bod;
    bod_flag = 1'b1;
    tick(1);
    chk(port_weak_pu, 1'b0, "R10", "pull-up not before edge 2");
    tick(1);
    chk(port_weak_pu, 1'b1, "R10", "pull-up at edge 2");
    tick(10);
    bod_flag = 1'b0;
    tick(1);
    chk(port_weak_pu, 1'b1, "R10", "pull-up held 1 edge after clear");
    tick(1);
    chk(port_weak_pu, 1'b0, "R10", "pull-up released at edge 2");
    tick(BOD_DLY - 1);
    chk(rst_int, 1'b0, "R11", "no reset before delay ends");
    tick(1);
    chk(rst_int, 1'b1, "R11", "brown-out reset after delay");
    chk(port_ones, 1'b1, "R1", "port_ones in brown-out reset");
    tick(23);
    chk(rst_int, 1'b1, "R11", "brown-out reset last cycle");
    tick(1);
    chk(rst_int, 1'b0, "R11", "brown-out reset 24 cycles long");
  endtask

  task automatic t_bod_restart;
    bod_flag = 1'b1;
    tick(4);
    bod_flag = 1'b0;
    tick(10);
    bod_flag = 1'b1;
    tick(4);
    bod_flag = 1'b0;
    tick(BOD_DLY + 1);
    chk(rst_int, 1'b0, "R11", "delay restarted by new brown-out");
    tick(1);
    chk(rst_int, 1'b1, "R11", "reset after restarted delay");
    tick(30);
  endtask

  task automatic t_req_in_reset;
    rst_pin_a = 1'b1;
    tick(26);
    pulse_req(1'b1, 1'b0);
    pulse_req(1'b0, 1'b1);
    rst_pin_a = 1'b0;
    tick(4);
    chk(rst_int, 1'b0, "R12", "reset released");
    chk(cpu_clk_en, 1'b1, "R12", "idle request ignored in reset");
    chk(per_clk_en, 1'b1, "R12", "power-down request ignored in reset");
    chk(osc_en, 1'b1, "R12", "oscillator kept in reset");
  endtask

  initial begin
    tick(2);
    por_n = 1'b1;
    tick(2);
    t_reset_state();
    t_pin_qualify();
    t_short_pulse();
    t_idle_irq();
    t_pdown_wake(1'b0);
    t_pdown_wake(1'b1);
    t_idle_pin_exit();
    t_bod();
    t_bod_restart();
    t_req_in_reset();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule